// File: doc/BRIEF.md
# Dual-Bank Register File with Access Checks

This block is the architectural register storage for a core with two execution sides. It holds two banks, A and B, each with sixteen 32-bit registers. Side 0 owns bank A and side 1 owns bank B. Each side has several local read ports and two local write ports into its own bank, plus one cross read port into the opposite bank. One shared port writes a 40-bit value into an even/odd register pair, and another shared port reads one back. The 40-bit value is held as the low word in the even register and the top byte in the odd register.

Every cycle the block looks at the access pattern on its inputs and reports any rule that is broken, each rule on its own error bit. When a rule concerns a write, the offending write is dropped at the clock edge. Each side also picks a predicate source register with a 3-bit code, and the block reports whether that condition lets the instruction execute. All reads, the predicate results and the error bits are combinational on the current inputs and storage. Writes take effect at the rising clock edge.

Top module: `dual_rf`

## Requirements
- R1: An active-low asynchronous reset clears all 32 registers to zero.
- R2: A write on a side's write port updates that side's own bank (side 0 is bank A, side 1 is bank B) at the clock edge. Local read ports return the current content of the addressed register in that side's own bank without waiting for a clock.
- R3: The cross read port of side 0 returns a bank B register, and the cross read port of side 1 returns a bank A register.
- R4: A write with its low-half flag set replaces only bits 15:0 of the destination and keeps bits 31:16.
- R5: A 40-bit write to pair p stores bits 31:0 in register 2p and stores bits 39:32 in bits 7:0 of register 2p+1, with bits 31:8 of that register cleared. A 40-bit read of pair p returns {reg[2p+1][7:0], reg[2p]}.
- R6: When a 40-bit read and a 40-bit write are both requested in one cycle, err_o[0] is set and the 40-bit write is dropped. Local writes in that cycle still take effect.
- R7: err_o[1] is set when one register is read more than four times in a cycle. Each of the following counts as one read of a register: an enabled local read, an enabled cross read, each register of an enabled 40-bit read, and each predicate lookup. Storage is not affected.
- R8: When two writes target the same register in one cycle (local ports or either half of the 40-bit write), err_o[2] is set and that register keeps its old value. Other writes in the same cycle proceed.
- R9: Predicate code 0 is unconditional and always gives pred_ok_o=1. Codes 1 to 5 select A1, A2, B0, B1 and B2 in that order, and give pred_ok_o=1 exactly when the selected register is nonzero.
- R10: Predicate codes 6 and 7 are illegal. They give pred_ok_o=0 for that side and set err_o[3].
- R11: All error bits reflect the inputs of the same cycle, before the clock edge at which the writes would land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 2x4 | Local read enables per side (count toward fan-out) |
| rd_addr_i | input | 2x4x4 | Local read addresses per side |
| rd_data_o | output | 2x4x32 | Local read data per side |
| xrd_en_i | input | 2 | Cross read enable per side |
| xrd_addr_i | input | 2x4 | Cross read address per side (opposite bank) |
| xrd_data_o | output | 2x32 | Cross read data per side |
| wr_en_i | input | 2x2 | Local write enables per side |
| wr_addr_i | input | 2x2x4 | Local write addresses |
| wr_data_i | input | 2x2x32 | Local write data |
| wr_lo_i | input | 2x2 | Low-half-only write flag |
| lw_en_i | input | 1 | 40-bit write enable |
| lw_bank_i | input | 1 | 40-bit write bank (0 = A, 1 = B) |
| lw_pair_i | input | 3 | 40-bit write pair index |
| lw_data_i | input | 40 | 40-bit write data |
| lr_en_i | input | 1 | 40-bit read enable |
| lr_bank_i | input | 1 | 40-bit read bank |
| lr_pair_i | input | 3 | 40-bit read pair index |
| lr_data_o | output | 40 | 40-bit read data |
| pred_sel_i | input | 2x3 | Predicate code per side |
| pred_ok_o | output | 2 | Predicate result per side |
| err_o | output | 4 | Errors: 0 long read/write, 1 fan-out, 2 write clash, 3 bad predicate |

## Verification
The assertions assume that every input holds a known value from the first active clock edge and settles well before each rising edge. They also assume that a low-half or full write on side 0 port 0 is judged only when no write clash is flagged. The stimulus meets this because it drives every input at the falling edge, starting from an all-zero pattern during reset. Addresses are biased toward a few low registers so that clashes, fan-out overruns and colliding 40-bit pairs occur often among otherwise random patterns.

// File: rtl/dual_rf_pkg.sv
package dual_rf_pkg;
  localparam int NB     = 2;
  localparam int PSEL_W = 3;
  localparam int ERR_W  = 4;
  localparam int ERR_LONG_RW  = 0;
  localparam int ERR_FANOUT   = 1;
  localparam int ERR_WR_CLASH = 2;
  localparam int ERR_PRED     = 3;

  typedef struct packed {
    logic       valid;
    logic       bank;
    logic [1:0] idx;
  } pred_src_t;

  function automatic pred_src_t pred_decode(input logic [PSEL_W-1:0] sel);
    pred_src_t s;
    case (sel)
      3'd1:    s = '{valid: 1'b1, bank: 1'b0, idx: 2'd1};
      3'd2:    s = '{valid: 1'b1, bank: 1'b0, idx: 2'd2};
      3'd3:    s = '{valid: 1'b1, bank: 1'b1, idx: 2'd0};
      3'd4:    s = '{valid: 1'b1, bank: 1'b1, idx: 2'd1};
      3'd5:    s = '{valid: 1'b1, bank: 1'b1, idx: 2'd2};
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DATA_W   = 32,
  parameter int EXT_W    = 8,
  parameter int NUM_REGS = 16,
  parameter int WR_PORTS = 2,
  localparam int AW = $clog2(NUM_REGS),
  localparam int PW = AW - 1,
  localparam int LW = DATA_W + EXT_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [WR_PORTS-1:0]                 we_i,
  input  logic [WR_PORTS-1:0][AW-1:0]         wa_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]     wd_i,
  input  logic [WR_PORTS-1:0]                 wlo_i,
  input  logic                                lw_en_i,
  input  logic [PW-1:0]                       lw_pair_i,
  input  logic [LW-1:0]                       lw_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]     regs_o,
  output logic                                clash_o
);
  localparam int CW = $clog2(WR_PORTS + 2);

  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] clash;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CW-1:0]     hits;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      hits = '0;
      nxt  = regs_q[r];
      for (int p = 0; p < WR_PORTS; p++) begin
        if (we_i[p] && wa_i[p] == AW'(r)) begin
          hits = hits + CW'(1);
          nxt  = wlo_i[p] ? {regs_q[r][DATA_W-1:16], wd_i[p][15:0]} : wd_i[p];
        end
      end
      if (lw_en_i && lw_pair_i == PW'(r / 2)) begin
        hits = hits + CW'(1);
        if ((r % 2) == 0) nxt = lw_data_i[DATA_W-1:0];
        else              nxt = DATA_W'(lw_data_i[LW-1:DATA_W]);
      end
    end

    assign clash[r]  = hits > CW'(1);
    assign regs_o[r] = regs_q[r];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              regs_q[r] <= '0;
      else if (hits == CW'(1))  regs_q[r] <= nxt;
    end
  end

  assign clash_o = |clash;
endmodule

// File: rtl/rf_fanout.sv
module rf_fanout #(
  parameter int NUM_REGS = 16,
  parameter int NREQ     = 14,
  parameter int FAN_MAX  = 4,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(NREQ + 1)
) (
  input  logic [NREQ-1:0]         req_v_i,
  input  logic [NREQ-1:0]         req_b_i,
  input  logic [NREQ-1:0][AW-1:0] req_a_i,
  output logic                    over_o
);
  always_comb begin
    over_o = 1'b0;
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        logic [CW-1:0] cnt;
        cnt = '0;
        for (int k = 0; k < NREQ; k++) begin
          if (req_v_i[k] && req_b_i[k] == 1'(b) && req_a_i[k] == AW'(r))
            cnt = cnt + CW'(1);
        end
        if (cnt > CW'(FAN_MAX)) over_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_pred.sv
module rf_pred
  import dual_rf_pkg::*;
(
  input  logic [PSEL_W-1:0] sel_i,
  output pred_src_t         src_o,
  output logic              uncond_o,
  output logic              illegal_o
);
  assign src_o     = pred_decode(sel_i);
  assign uncond_o  = sel_i == '0;
  assign illegal_o = !uncond_o && !src_o.valid;
endmodule

// File: rtl/dual_rf.sv
module dual_rf
  import dual_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EXT_W    = 8,
  parameter int NUM_REGS = 16,
  parameter int RD_PORTS = 4,
  parameter int WR_PORTS = 2,
  parameter int FAN_MAX  = 4,
  localparam int AW = $clog2(NUM_REGS),
  localparam int PW = AW - 1,
  localparam int LW = DATA_W + EXT_W
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [NB-1:0][RD_PORTS-1:0]               rd_en_i,
  input  logic [NB-1:0][RD_PORTS-1:0][AW-1:0]       rd_addr_i,
  output logic [NB-1:0][RD_PORTS-1:0][DATA_W-1:0]   rd_data_o,
  input  logic [NB-1:0]                             xrd_en_i,
  input  logic [NB-1:0][AW-1:0]                     xrd_addr_i,
  output logic [NB-1:0][DATA_W-1:0]                 xrd_data_o,
  input  logic [NB-1:0][WR_PORTS-1:0]               wr_en_i,
  input  logic [NB-1:0][WR_PORTS-1:0][AW-1:0]       wr_addr_i,
  input  logic [NB-1:0][WR_PORTS-1:0][DATA_W-1:0]   wr_data_i,
  input  logic [NB-1:0][WR_PORTS-1:0]               wr_lo_i,
  input  logic                                      lw_en_i,
  input  logic                                      lw_bank_i,
  input  logic [PW-1:0]                             lw_pair_i,
  input  logic [LW-1:0]                             lw_data_i,
  input  logic                                      lr_en_i,
  input  logic                                      lr_bank_i,
  input  logic [PW-1:0]                             lr_pair_i,
  output logic [LW-1:0]                             lr_data_o,
  input  logic [NB-1:0][PSEL_W-1:0]                 pred_sel_i,
  output logic [NB-1:0]                             pred_ok_o,
  output logic [ERR_W-1:0]                          err_o
);
  localparam int K_XRD  = NB * RD_PORTS;
  localparam int K_LR   = K_XRD + NB;
  localparam int K_PRED = K_LR + 2;
  localparam int NREQ   = K_PRED + NB;

  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q [NB];
  logic [NB-1:0]                   clash;
  logic [NB-1:0]                   pred_bad;
  pred_src_t                       psrc [NB];
  logic                            long_rw;
  logic                            lw_eff;
  logic                            fan_over;
  logic [NREQ-1:0]                 req_v;
  logic [NREQ-1:0]                 req_b;
  logic [NREQ-1:0][AW-1:0]         req_a;

  assign long_rw = lw_en_i && lr_en_i;
  assign lw_eff  = lw_en_i && !long_rw;

  for (genvar s = 0; s < NB; s++) begin : g_side
    logic              uncond;
    logic [DATA_W-1:0] pval;

    rf_bank #(
      .DATA_W(DATA_W), .EXT_W(EXT_W), .NUM_REGS(NUM_REGS), .WR_PORTS(WR_PORTS)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_en_i[s]),
      .wa_i      (wr_addr_i[s]),
      .wd_i      (wr_data_i[s]),
      .wlo_i     (wr_lo_i[s]),
      .lw_en_i   (lw_eff && lw_bank_i == 1'(s)),
      .lw_pair_i (lw_pair_i),
      .lw_data_i (lw_data_i),
      .regs_o    (bank_q[s]),
      .clash_o   (clash[s])
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data_o[s][p] = bank_q[s][rd_addr_i[s][p]];
    end
    assign xrd_data_o[s] = bank_q[NB-1-s][xrd_addr_i[s]];

    rf_pred u_pred (
      .sel_i     (pred_sel_i[s]),
      .src_o     (psrc[s]),
      .uncond_o  (uncond),
      .illegal_o (pred_bad[s])
    );
    assign pval         = bank_q[psrc[s].bank][AW'(psrc[s].idx)];
    assign pred_ok_o[s] = uncond || (psrc[s].valid && |pval);
  end

  // 40-bit pair read: even word low, odd register's low byte on top
  assign lr_data_o = {bank_q[lr_bank_i][{lr_pair_i, 1'b1}][EXT_W-1:0],
                      bank_q[lr_bank_i][{lr_pair_i, 1'b0}]};

  always_comb begin
    for (int s = 0; s < NB; s++) begin
      for (int p = 0; p < RD_PORTS; p++) begin
        req_v[s*RD_PORTS+p] = rd_en_i[s][p];
        req_b[s*RD_PORTS+p] = 1'(s);
        req_a[s*RD_PORTS+p] = rd_addr_i[s][p];
      end
      req_v[K_XRD+s]  = xrd_en_i[s];
      req_b[K_XRD+s]  = (s == 0);
      req_a[K_XRD+s]  = xrd_addr_i[s];
      req_v[K_PRED+s] = psrc[s].valid;
      req_b[K_PRED+s] = psrc[s].bank;
      req_a[K_PRED+s] = AW'(psrc[s].idx);
    end
    req_v[K_LR]   = lr_en_i;
    req_b[K_LR]   = lr_bank_i;
    req_a[K_LR]   = {lr_pair_i, 1'b0};
    req_v[K_LR+1] = lr_en_i;
    req_b[K_LR+1] = lr_bank_i;
    req_a[K_LR+1] = {lr_pair_i, 1'b1};
  end

  rf_fanout #(
    .NUM_REGS(NUM_REGS), .NREQ(NREQ), .FAN_MAX(FAN_MAX)
  ) u_fanout (
    .req_v_i (req_v),
    .req_b_i (req_b),
    .req_a_i (req_a),
    .over_o  (fan_over)
  );

  assign err_o[ERR_LONG_RW]  = long_rw;
  assign err_o[ERR_FANOUT]   = fan_over;
  assign err_o[ERR_WR_CLASH] = |clash;
  assign err_o[ERR_PRED]     = |pred_bad;
endmodule

// File: rtl/dual_rf_chk.sv
module dual_rf_chk
  import dual_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int WR_PORTS = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input logic                                    clk_i,
  input logic                                    rst_ni,
  input logic [NB-1:0][WR_PORTS-1:0]             wr_en_i,
  input logic [NB-1:0][WR_PORTS-1:0][AW-1:0]     wr_addr_i,
  input logic [NB-1:0][WR_PORTS-1:0][DATA_W-1:0] wr_data_i,
  input logic [NB-1:0][WR_PORTS-1:0]             wr_lo_i,
  input logic                                    lw_en_i,
  input logic                                    lr_en_i,
  input logic [NB-1:0][PSEL_W-1:0]               pred_sel_i,
  input logic [NB-1:0]                           pred_ok_o,
  input logic [ERR_W-1:0]                        err_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0]         regs_i [NB]
);
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (regs_i[0] == '0 && regs_i[1] == '0));

  a_r2_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0][0] && !wr_lo_i[0][0] && !err_o[ERR_WR_CLASH]) |=>
      regs_i[0][$past(wr_addr_i[0][0])] == $past(wr_data_i[0][0]));

  a_r4_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0][0] && wr_lo_i[0][0] && !err_o[ERR_WR_CLASH]) |=>
      regs_i[0][$past(wr_addr_i[0][0])] ==
        {$past(regs_i[0][wr_addr_i[0][0]][DATA_W-1:16]), $past(wr_data_i[0][0][15:0])});

  a_r6_long_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_en_i && lr_en_i && wr_en_i == '0) |=> ($stable(regs_i[0]) && $stable(regs_i[1])));

  a_r8_clash_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0] == '1 && wr_addr_i[0][0] == wr_addr_i[0][1]) |-> err_o[ERR_WR_CLASH]);

  a_r8_clash_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0] == '1 && wr_addr_i[0][0] == wr_addr_i[0][1]) |=>
      regs_i[0][$past(wr_addr_i[0][0])] == $past(regs_i[0][wr_addr_i[0][0]]));

  for (genvar s = 0; s < NB; s++) begin : g_pchk
    a_r9_uncond: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pred_sel_i[s] == '0 |-> pred_ok_o[s]);
    a_r10_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pred_sel_i[s] > 3'd5 |-> (!pred_ok_o[s] && err_o[ERR_PRED]));
  end
endmodule

bind dual_rf dual_rf_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WR_PORTS(WR_PORTS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .wr_lo_i    (wr_lo_i),
  .lw_en_i    (lw_en_i),
  .lr_en_i    (lr_en_i),
  .pred_sel_i (pred_sel_i),
  .pred_ok_o  (pred_ok_o),
  .err_o      (err_o),
  .regs_i     (bank_q)
);

// File: tb/dual_rf_test.sv
module dual_rf_test;
  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [1:0][3:0]        rd_en;
  logic [1:0][3:0][3:0]   rd_addr;
  logic [1:0][3:0][31:0]  rd_data;
  logic [1:0]             xrd_en;
  logic [1:0][3:0]        xrd_addr;
  logic [1:0][31:0]       xrd_data;
  logic [1:0][1:0]        wr_en;
  logic [1:0][1:0][3:0]   wr_addr;
  logic [1:0][1:0][31:0]  wr_data;
  logic [1:0][1:0]        wr_lo;
  logic                   lw_en, lw_bank, lr_en, lr_bank;
  logic [2:0]             lw_pair, lr_pair;
  logic [39:0]            lw_data, lr_data;
  logic [1:0][2:0]        psel;
  logic [1:0]             pok;
  logic [3:0]             err;

  logic [31:0] m [2][16];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  dual_rf uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .xrd_en_i(xrd_en), .xrd_addr_i(xrd_addr), .xrd_data_o(xrd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_lo_i(wr_lo),
    .lw_en_i(lw_en), .lw_bank_i(lw_bank), .lw_pair_i(lw_pair), .lw_data_i(lw_data),
    .lr_en_i(lr_en), .lr_bank_i(lr_bank), .lr_pair_i(lr_pair), .lr_data_o(lr_data),
    .pred_sel_i(psel), .pred_ok_o(pok), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    rd_en = '0; rd_addr = '0; xrd_en = '0; xrd_addr = '0;
    wr_en = '0; wr_addr = '0; wr_data = '0; wr_lo = '0;
    lw_en = 0; lw_bank = 0; lw_pair = '0; lw_data = '0;
    lr_en = 0; lr_bank = 0; lr_pair = '0; psel = '0;
  endtask

  // predicate code -> (valid, bank, reg)
  function automatic void pmap(input logic [2:0] c, output bit v, output int b, output int r);
    v = 1; b = 0; r = 0;
    case (c)
      3'd1: begin b = 0; r = 1; end
      3'd2: begin b = 0; r = 2; end
      3'd3: begin b = 1; r = 0; end
      3'd4: begin b = 1; r = 1; end
      3'd5: begin b = 1; r = 2; end
      default: v = 0;
    endcase
  endfunction

  task automatic step();
    int cnt [2][16];
    logic [31:0] nx [2][16];
    bit e_fan, e_clash, e_pred, pv;
    int pb, pr;
    #1;
    foreach (cnt[b, r]) cnt[b][r] = 0;
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 4; p++) begin
        chk(rd_data[s][p] == m[s][rd_addr[s][p]], "R2 local read", 64'(rd_data[s][p]), 64'(m[s][rd_addr[s][p]]));
        if (rd_en[s][p]) cnt[s][rd_addr[s][p]]++;
      end
      chk(xrd_data[s] == m[1-s][xrd_addr[s]], "R3 cross read", 64'(xrd_data[s]), 64'(m[1-s][xrd_addr[s]]));
      if (xrd_en[s]) cnt[1-s][xrd_addr[s]]++;
    end
    chk(lr_data == {m[lr_bank][2*lr_pair+1][7:0], m[lr_bank][2*lr_pair]}, "R5 long read",
        64'(lr_data), 64'({m[lr_bank][2*lr_pair+1][7:0], m[lr_bank][2*lr_pair]}));
    if (lr_en) begin cnt[lr_bank][2*lr_pair]++; cnt[lr_bank][2*lr_pair+1]++; end
    e_pred = 0;
    for (int s = 0; s < 2; s++) begin
      bit exp_ok;
      pmap(psel[s], pv, pb, pr);
      if (psel[s] == 0) exp_ok = 1;
      else if (!pv) begin exp_ok = 0; e_pred = 1; end
      else begin exp_ok = (m[pb][pr] != 0); cnt[pb][pr]++; end
      chk(pok[s] == exp_ok, psel[s] > 5 ? "R10 predicate" : "R9 predicate", 64'(pok[s]), 64'(exp_ok));
    end
    e_fan = 0;
    foreach (cnt[b, r]) if (cnt[b][r] > 4) e_fan = 1;
    // next state per register
    e_clash = 0;
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 16; r++) begin
        int hits = 0;
        logic [31:0] v = m[b][r];
        for (int p = 0; p < 2; p++) begin
          if (wr_en[b][p] && wr_addr[b][p] == r) begin
            hits++;
            v = wr_lo[b][p] ? {m[b][r][31:16], wr_data[b][p][15:0]} : wr_data[b][p];
          end
        end
        if (lw_en && !lr_en && lw_bank == b && lw_pair == r / 2) begin
          hits++;
          v = (r % 2 == 0) ? lw_data[31:0] : {24'h0, lw_data[39:32]};
        end
        if (hits > 1) e_clash = 1;
        nx[b][r] = (hits == 1) ? v : m[b][r];
      end
    end
    chk(err[0] == (lw_en && lr_en), "R6 R11 long rw flag", 64'(err[0]), 64'(lw_en && lr_en));
    chk(err[1] == e_fan, "R7 R11 fanout flag", 64'(err[1]), 64'(e_fan));
    chk(err[2] == e_clash, "R8 R11 clash flag", 64'(err[2]), 64'(e_clash));
    chk(err[3] == e_pred, "R10 R11 predicate flag", 64'(err[3]), 64'(e_pred));
    foreach (m[b, r]) m[b][r] = nx[b][r];
    @(negedge clk);
  endtask

  function automatic logic [3:0] raddr();
    return ($urandom % 3 == 0) ? 4'($urandom % 4) : 4'($urandom % 16);
  endfunction

  initial begin
    seed_v = $urandom(32'h1f2e3d);
    clear_in();
    rst_n = 0;
    foreach (m[b, r]) m[b][r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every register reads zero after reset
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 16; r++) begin
        rd_addr[s][0] = 4'(r);
        #0.1;
        chk(rd_data[s][0] == 0, "R1 reset value", 64'(rd_data[s][0]), 64'h0);
      end
    end
    chk(err == 0, "R1 no error at rest", 64'(err), 64'h0);
    clear_in();
    @(negedge clk);

    // R2/R3 directed
    wr_en[0][0] = 1; wr_addr[0][0] = 5; wr_data[0][0] = 32'hCAFE0001;
    wr_en[1][1] = 1; wr_addr[1][1] = 7; wr_data[1][1] = 32'h0BAD0007;
    step();
    clear_in();
    rd_addr[0][0] = 5; xrd_addr[1] = 5; xrd_addr[0] = 7;
    #1;
    chk(rd_data[0][0] == 32'hCAFE0001, "R2 bank A write", 64'(rd_data[0][0]), 64'hCAFE0001);
    chk(xrd_data[1] == 32'hCAFE0001, "R3 side1 reads A", 64'(xrd_data[1]), 64'hCAFE0001);
    chk(xrd_data[0] == 32'h0BAD0007, "R3 side0 reads B", 64'(xrd_data[0]), 64'h0BAD0007);
    step();

    // R4 low-half write
    wr_en[0][0] = 1; wr_addr[0][0] = 3; wr_data[0][0] = 32'hFFFFFFFF;
    step();
    wr_lo[0][0] = 1; wr_data[0][0] = 32'h00001234;
    step();
    clear_in(); rd_addr[0][0] = 3;
    #1;
    chk(rd_data[0][0] == 32'hFFFF1234, "R4 low half only", 64'(rd_data[0][0]), 64'hFFFF1234);
    step();

    // R5 40-bit pair write into bank B pair 2
    lw_en = 1; lw_bank = 1; lw_pair = 2; lw_data = 40'hAB_1234_5678;
    step();
    clear_in(); lr_bank = 1; lr_pair = 2; rd_addr[1][0] = 5; rd_addr[1][1] = 4;
    #1;
    chk(lr_data == 40'hAB_1234_5678, "R5 long read back", 64'(lr_data), 64'hAB12345678);
    chk(rd_data[1][0] == 32'h000000AB, "R5 odd register", 64'(rd_data[1][0]), 64'hAB);
    chk(rd_data[1][1] == 32'h12345678, "R5 even register", 64'(rd_data[1][1]), 64'h12345678);
    step();

    // R6 long read and write together: long write dropped, local write kept
    lw_en = 1; lw_bank = 0; lw_pair = 3; lw_data = 40'h11_2222_3333;
    lr_en = 1; lr_bank = 1; lr_pair = 2;
    wr_en[0][0] = 1; wr_addr[0][0] = 0; wr_data[0][0] = 32'h5A5A5A5A;
    #1;
    chk(err[0] == 1, "R6 flag raised", 64'(err[0]), 64'h1);
    step();
    clear_in(); rd_addr[0][0] = 6; rd_addr[0][1] = 7; rd_addr[0][2] = 0;
    #1;
    chk(rd_data[0][0] == 0 && rd_data[0][1] == 0, "R6 pair untouched", 64'({rd_data[0][1], rd_data[0][0]}), 64'h0);
    chk(rd_data[0][2] == 32'h5A5A5A5A, "R6 local write kept", 64'(rd_data[0][2]), 64'h5A5A5A5A);
    step();

    // R7 fan-out: four reads allowed, five flagged
    rd_en[0] = 4'hF; rd_addr[0] = {4'd9, 4'd9, 4'd9, 4'd9};
    #1;
    chk(err[1] == 0, "R7 four reads ok", 64'(err[1]), 64'h0);
    step();
    rd_en[0] = 4'hF; rd_addr[0] = {4'd9, 4'd9, 4'd9, 4'd9};
    xrd_en[1] = 1; xrd_addr[1] = 9;
    #1;
    chk(err[1] == 1, "R7 five reads flagged", 64'(err[1]), 64'h1);
    step();
    clear_in();

    // R8 clash: A4 keeps old value, B4 written
    wr_en[0] = 2'b11; wr_addr[0] = {4'd4, 4'd4}; wr_data[0] = {32'h1, 32'h2};
    wr_en[1][0] = 1; wr_addr[1][0] = 4; wr_data[1][0] = 32'h44;
    #1;
    chk(err[2] == 1, "R8 clash flagged", 64'(err[2]), 64'h1);
    step();
    clear_in(); rd_addr[0][0] = 4; rd_addr[1][0] = 4;
    #1;
    chk(rd_data[0][0] == 0, "R8 clashed reg held", 64'(rd_data[0][0]), 64'h0);
    chk(rd_data[1][0] == 32'h44, "R8 other write proceeds", 64'(rd_data[1][0]), 64'h44);
    step();

    // R9 predicates: A1 zero, B2 nonzero
    wr_en[1][0] = 1; wr_addr[1][0] = 2; wr_data[1][0] = 32'h5;
    step();
    clear_in(); psel[0] = 3'd1; psel[1] = 3'd5;
    #1;
    chk(pok[0] == 0, "R9 A1 zero", 64'(pok[0]), 64'h0);
    chk(pok[1] == 1, "R9 B2 nonzero", 64'(pok[1]), 64'h1);
    step();

    // R10 illegal code
    psel[0] = 3'd7; psel[1] = 3'd0;
    #1;
    chk(pok[0] == 0 && err[3] == 1, "R10 illegal code", 64'({pok[0], err[3]}), 64'h1);
    step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 4; p++) begin
          rd_en[s][p] = 1'($urandom % 4 != 0);
          rd_addr[s][p] = raddr();
        end
        xrd_en[s] = 1'($urandom % 2);
        xrd_addr[s] = raddr();
        for (int p = 0; p < 2; p++) begin
          wr_en[s][p] = 1'($urandom % 2);
          wr_addr[s][p] = raddr();
          wr_data[s][p] = ($urandom % 4 == 0) ? 32'h0 : $urandom;
          wr_lo[s][p] = 1'($urandom % 4 == 0);
        end
        psel[s] = 3'($urandom % 8);
      end
      lw_en = 1'($urandom % 3 == 0); lw_bank = 1'($urandom % 2);
      lw_pair = 3'($urandom % 8); lw_data = {8'($urandom), 32'($urandom)};
      lr_en = 1'($urandom % 3 == 0); lr_bank = 1'($urandom % 2);
      lr_pair = 3'($urandom % 8);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule